// File: doc/BRIEF.md
# Dual-Loop Digital Phase Adjust Controller

This block is the digital outer loop that sits at the adjusting end of an asymmetric serial link. It owns four phase codes, one for each clock phase adjuster: the divider clock, the transmit clock, the data-receive clock and the timing-receive clock. Each code counts positions around one VCO cycle: a ring of `N_PH` VCO phases, with `2**FINE_W` interpolator steps between each pair of neighbouring phases. The defaults are 12 phases and 16 steps, which gives 192 codes. Every code leaves the block split into a coarse index `k`, which selects the phase pair k and k+1 modulo `N_PH`, and a fine interpolator weight.

The receive code follows the local timing receivers sample by sample. The transmit code moves only inside calibration windows, on a majority decision over a group of timing samples returned by the far end. After any step, a loop ignores its samples for a set number of cycles so that the step can travel around the outer loop first. The timing-receive code is slaved to the data-receive code at a fixed offset. The divider code is a constant. For margin measurement, any of the four codes can be forced from outside.

Top module: `phadj_ctrl`

## Requirements
- R1: After reset the divider code is `DIV_CODE`, the transmit code is `TX_INIT`, the data-receive code is `RX_INIT`, and the timing-receive code is (`RX_INIT`+`RXT_OFS`) mod `NCODE`.
- R2: Every output code c lies in 0..`NCODE`-1 and is presented as coarse = c / 2**`FINE_W` and fine = c mod 2**`FINE_W` (c[3:0] by default).
- R3: An accepted receive sample with only `rx_early` set steps the data-receive code up by one. One with only `rx_late` set steps it down by one. One with both flags set or neither set causes no step.
- R4: Steps wrap: up from `NCODE`-1 gives 0, and down from 0 gives `NCODE`-1.
- R5: The timing-receive code always equals (effective data-receive code + `RXT_OFS`) mod `NCODE` unless the timing-receive code is itself overridden.
- R6: The transmit code changes only on a clock edge at which `cal_win` is high. Far-end samples outside a window have no effect.
- R7: The transmit loop counts `VOTE_N` accepted far samples, each marked early, late or abstain (both flags set or neither set). At the last of them it steps up if the early count exceeds the late count, steps down if the late count exceeds the early count, and otherwise makes no step.
- R8: When `cal_win` drops, a partly gathered vote is discarded.
- R9: After a step, the samples of that loop on the next `RX_LOCK` (receive) or `TX_LOCK` (transmit) clock edges are ignored.
- R10: While `ovr_en[i]` is set, output i shows `ovr_code` slot i folded into range (values ≥ `NCODE` have `NCODE` subtracted). The loop behind that output takes no samples and keeps its code, which reappears on release. Slots are 0 divider, 1 transmit, 2 data-receive, 3 timing-receive.
- R11: The divider code never changes except under override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_vld | input | 1 | Local timing-receiver sample valid |
| rx_early | input | 1 | Local sample says step the receive phase up |
| rx_late | input | 1 | Local sample says step the receive phase down |
| cal_win | input | 1 | Calibration window active |
| far_vld | input | 1 | Far-end timing sample valid |
| far_early | input | 1 | Far sample votes up |
| far_late | input | 1 | Far sample votes down |
| ovr_en | input | 4 | Per-slot override enable |
| ovr_code | input | 4*CW | Override codes, slot i at bits [i*CW +: CW] |
| div_crs | output | CRS_W | Divider coarse phase index |
| div_fin | output | FINE_W | Divider interpolator weight |
| tx_crs | output | CRS_W | Transmit coarse phase index |
| tx_fin | output | FINE_W | Transmit interpolator weight |
| rxd_crs | output | CRS_W | Data-receive coarse phase index |
| rxd_fin | output | FINE_W | Data-receive interpolator weight |
| rxt_crs | output | CRS_W | Timing-receive coarse phase index |
| rxt_fin | output | FINE_W | Timing-receive interpolator weight |

## Verification
The assertions check four things on every cycle: that each loop code stays in range, that it moves by at most one wrapped step, that it holds still during lockout and override, and that the transmit code moves only on window edges. They also check that a vote never asks for both directions at once. Only the bench scenarios can show the arithmetic results: the direction a given mix of votes produces, the discarding of a vote when its window closes, the folding of override values, the slaved timing-receive offset, and the exact values across the wrap points.

// File: rtl/phadj_pkg.sv
package phadj_pkg;
   typedef enum logic [1:0] {
      SLOT_DIV = 2'd0,
      SLOT_TX  = 2'd1,
      SLOT_RXD = 2'd2,
      SLOT_RXT = 2'd3
   } phadj_slot_e;

   localparam int unsigned N_SLOTS = 4;
endpackage

// File: rtl/phadj_vote.sv
module phadj_vote #(
   parameter int unsigned N = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic vld,
   input  logic early,
   input  logic late,
   output logic up,
   output logic dn
);
   generate
      if (N == 1) begin : g_direct
         logic unused_clr;
         assign unused_clr = clr;
         assign up = vld & early & ~late;
         assign dn = vld & late & ~early;
      end else begin : g_count
         localparam int unsigned CNT_W = $clog2(N + 1);
         logic [CNT_W-1:0] n_q, e_q, l_q;
         logic [CNT_W-1:0] e_nx, l_nx;
         logic             last;

         assign e_nx = e_q + CNT_W'(vld & early & ~late);
         assign l_nx = l_q + CNT_W'(vld & late & ~early);
         assign last = vld && (n_q == CNT_W'(N - 1));
         assign up   = last && (e_nx > l_nx);
         assign dn   = last && (l_nx > e_nx);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               n_q <= '0;
               e_q <= '0;
               l_q <= '0;
            end else if (clr || last) begin
               n_q <= '0;
               e_q <= '0;
               l_q <= '0;
            end else if (vld) begin
               n_q <= n_q + 1'b1;
               e_q <= e_nx;
               l_q <= l_nx;
            end
         end

         // R8
         vote_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (n_q == '0));
      end
   endgenerate

   // R7
   vote_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(up && dn));
endmodule

// File: rtl/phadj_stepper.sv
module phadj_stepper #(
   parameter int unsigned NCODE = 192,
   parameter int unsigned CW    = 8,
   parameter int unsigned INIT  = 0,
   parameter int unsigned LOCK  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_up,
   input  logic          smp_dn,
   input  logic          hold,
   output logic [CW-1:0] code,
   output logic          busy
);
   logic [CW-1:0] code_q, inc, dec;
   logic          step;

   assign step = (smp_up ^ smp_dn) & ~hold & ~busy;
   assign inc  = (code_q == CW'(NCODE - 1)) ? '0 : code_q + 1'b1;
   assign dec  = (code_q == '0) ? CW'(NCODE - 1) : code_q - 1'b1;
   assign code = code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    code_q <= CW'(INIT);
      else if (step) code_q <= smp_up ? inc : dec;
   end

   generate
      if (LOCK == 0) begin : g_nolock
         assign busy = 1'b0;
      end else begin : g_lock
         localparam int unsigned LW = $clog2(LOCK + 1);
         logic [LW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt_q <= '0;
            else if (step)         cnt_q <= LW'(LOCK);
            else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
         end
         assign busy = (cnt_q != '0);
      end
   endgenerate

   // R2
   code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, code} < (CW+1)'(NCODE)));

   // R4
   step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code != $past(code)) |->
         ((code == (($past(code) == CW'(NCODE - 1)) ? CW'(0) : $past(code) + CW'(1))) ||
          (code == (($past(code) == CW'(0)) ? CW'(NCODE - 1) : $past(code) - CW'(1)))));

   // R9
   lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(code));

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(code));
endmodule

// File: rtl/phadj_ctrl.sv
module phadj_ctrl #(
   parameter int unsigned N_PH      = 12,
   parameter int unsigned FINE_W    = 4,
   parameter int unsigned VOTE_N    = 7,
   parameter int unsigned RX_VOTE_N = 1,
   parameter int unsigned RX_LOCK   = 4,
   parameter int unsigned TX_LOCK   = 8,
   parameter int unsigned DIV_CODE  = 0,
   parameter int unsigned TX_INIT   = 0,
   parameter int unsigned RX_INIT   = 0,
   parameter int unsigned RXT_OFS   = 96,
   localparam int unsigned NCODE    = N_PH << FINE_W,
   localparam int unsigned CW       = $clog2(NCODE),
   localparam int unsigned CRS_W    = CW - FINE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_vld,
   input  logic                rx_early,
   input  logic                rx_late,
   input  logic                cal_win,
   input  logic                far_vld,
   input  logic                far_early,
   input  logic                far_late,
   input  logic [3:0]          ovr_en,
   input  logic [4*CW-1:0]     ovr_code,
   output logic [CRS_W-1:0]    div_crs,
   output logic [FINE_W-1:0]   div_fin,
   output logic [CRS_W-1:0]    tx_crs,
   output logic [FINE_W-1:0]   tx_fin,
   output logic [CRS_W-1:0]    rxd_crs,
   output logic [FINE_W-1:0]   rxd_fin,
   output logic [CRS_W-1:0]    rxt_crs,
   output logic [FINE_W-1:0]   rxt_fin
);
   import phadj_pkg::*;

   generate
      if (N_PH < 2)                  begin : g_bad_ph   $error("N_PH must be at least 2"); end
      if (VOTE_N % 2 == 0)           begin : g_bad_vote $error("VOTE_N must be odd"); end
      if (RX_VOTE_N % 2 == 0)        begin : g_bad_rxv  $error("RX_VOTE_N must be odd"); end
      if (RXT_OFS >= NCODE)          begin : g_bad_ofs  $error("RXT_OFS out of range"); end
      if (DIV_CODE >= NCODE)         begin : g_bad_div  $error("DIV_CODE out of range"); end
      if (TX_INIT >= NCODE)          begin : g_bad_tx   $error("TX_INIT out of range"); end
      if (RX_INIT >= NCODE)          begin : g_bad_rx   $error("RX_INIT out of range"); end
   endgenerate

   // folded override codes, one per slot
   logic [CW-1:0] ovr_f [N_SLOTS];
   for (genvar i = 0; i < N_SLOTS; i++) begin : g_fold
      logic [CW-1:0] raw;
      assign raw      = ovr_code[i*CW +: CW];
      assign ovr_f[i] = ({1'b0, raw} >= (CW+1)'(NCODE)) ? raw - CW'(NCODE) : raw;
   end

   // receive loop
   logic          rx_busy, rx_up, rx_dn;
   logic [CW-1:0] rxd_loop;

   phadj_vote #(.N(RX_VOTE_N)) u_rx_vote (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (1'b0),
      .vld   (rx_vld & ~rx_busy & ~ovr_en[SLOT_RXD]),
      .early (rx_early),
      .late  (rx_late),
      .up    (rx_up),
      .dn    (rx_dn)
   );

   phadj_stepper #(.NCODE(NCODE), .CW(CW), .INIT(RX_INIT), .LOCK(RX_LOCK)) u_rx_step (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_up (rx_up),
      .smp_dn (rx_dn),
      .hold   (ovr_en[SLOT_RXD]),
      .code   (rxd_loop),
      .busy   (rx_busy)
   );

   // transmit loop
   logic          tx_busy, tx_up, tx_dn;
   logic [CW-1:0] tx_loop;

   phadj_vote #(.N(VOTE_N)) u_tx_vote (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (~cal_win),
      .vld   (far_vld & cal_win & ~tx_busy & ~ovr_en[SLOT_TX]),
      .early (far_early),
      .late  (far_late),
      .up    (tx_up),
      .dn    (tx_dn)
   );

   phadj_stepper #(.NCODE(NCODE), .CW(CW), .INIT(TX_INIT), .LOCK(TX_LOCK)) u_tx_step (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_up (tx_up),
      .smp_dn (tx_dn),
      .hold   (ovr_en[SLOT_TX]),
      .code   (tx_loop),
      .busy   (tx_busy)
   );

   // effective codes
   logic [CW-1:0] div_eff, tx_eff, rxd_eff, rxt_eff, rxt_loop;
   logic [CW:0]   rxt_sum;

   assign rxd_eff  = ovr_en[SLOT_RXD] ? ovr_f[SLOT_RXD] : rxd_loop;
   assign rxt_sum  = {1'b0, rxd_eff} + (CW+1)'(RXT_OFS);
   assign rxt_loop = (rxt_sum >= (CW+1)'(NCODE)) ? CW'(rxt_sum - (CW+1)'(NCODE)) : rxt_sum[CW-1:0];
   assign rxt_eff  = ovr_en[SLOT_RXT] ? ovr_f[SLOT_RXT] : rxt_loop;
   assign tx_eff   = ovr_en[SLOT_TX]  ? ovr_f[SLOT_TX]  : tx_loop;
   assign div_eff  = ovr_en[SLOT_DIV] ? ovr_f[SLOT_DIV] : CW'(DIV_CODE);

   assign {div_crs, div_fin} = div_eff;
   assign {tx_crs,  tx_fin}  = tx_eff;
   assign {rxd_crs, rxd_fin} = rxd_eff;
   assign {rxt_crs, rxt_fin} = rxt_eff;

   // R6
   tx_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_loop != $past(tx_loop)) |-> $past(cal_win));
endmodule

// File: tb/phadj_ctrl_tb.sv
`timescale 1ns/1ps
module phadj_ctrl_tb;
   localparam int unsigned RXL = 2;
   localparam int unsigned TXL = 3;
   localparam int unsigned DIVC = 37;
   localparam int unsigned NC = 192;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_vld = 0, rx_early = 0, rx_late = 0;
   logic cal_win = 0, far_vld = 0, far_early = 0, far_late = 0;
   logic [3:0]  ovr_en = '0;
   logic [31:0] ovr_code = '0;
   logic [3:0] div_crs, div_fin, tx_crs, tx_fin, rxd_crs, rxd_fin, rxt_crs, rxt_fin;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   phadj_ctrl #(.VOTE_N(7), .RX_LOCK(RXL), .TX_LOCK(TXL), .DIV_CODE(DIVC),
                .TX_INIT(0), .RX_INIT(0), .RXT_OFS(96)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .rx_vld(rx_vld), .rx_early(rx_early), .rx_late(rx_late),
      .cal_win(cal_win), .far_vld(far_vld), .far_early(far_early), .far_late(far_late),
      .ovr_en(ovr_en), .ovr_code(ovr_code),
      .div_crs(div_crs), .div_fin(div_fin), .tx_crs(tx_crs), .tx_fin(tx_fin),
      .rxd_crs(rxd_crs), .rxd_fin(rxd_fin), .rxt_crs(rxt_crs), .rxt_fin(rxt_fin)
   );

   task automatic chk(input string req, input logic [3:0] crs, input logic [3:0] fin, input int exp_code);
      logic [7:0] exp_v;
      exp_v = {4'(exp_code / 16), 4'(exp_code % 16)};
      total++;
      if ({crs, fin} !== exp_v) begin
         bad++;
         $display("FAIL %s: actual crs=%0d fin=%0d expected crs=%0d fin=%0d",
                  req, crs, fin, exp_v[7:4], exp_v[3:0]);
      end
   endtask

   task automatic rx_pulse(input logic e, input logic l);
      rx_vld = 1; rx_early = e; rx_late = l;
      @(negedge clk);
      rx_vld = 0; rx_early = 0; rx_late = 0;
      repeat (RXL) @(negedge clk);
   endtask

   task automatic far_smp(input logic e, input logic l);
      far_vld = 1; far_early = e; far_late = l;
      @(negedge clk);
      far_vld = 0; far_early = 0; far_late = 0;
      repeat (TXL) @(negedge clk);
   endtask

   // {vld, early, late, expected data-receive code}
   localparam logic [10:0] VEC [9] = '{
      {3'b110, 8'd1},   // early: up
      {3'b101, 8'd0},   // late: down
      {3'b101, 8'd191}, // late: wrap down
      {3'b111, 8'd191}, // both: no step
      {3'b100, 8'd191}, // neither: no step
      {3'b110, 8'd0},   // early: wrap up
      {3'b110, 8'd1},
      {3'b010, 8'd1},   // not valid: ignored
      {3'b101, 8'd0}
   };

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state (sampled while reset still held)
      chk("R1 div", div_crs, div_fin, DIVC);
      chk("R1 tx", tx_crs, tx_fin, 0);
      chk("R1 rxd", rxd_crs, rxd_fin, 0);
      chk("R1 rxt", rxt_crs, rxt_fin, 96);
      rst_n = 1;
      @(negedge clk);

      // R3 R4 R5: table walk of receive samples
      foreach (VEC[i]) begin
         rx_vld = VEC[i][10]; rx_early = VEC[i][9]; rx_late = VEC[i][8];
         @(negedge clk);
         rx_vld = 0; rx_early = 0; rx_late = 0;
         repeat (RXL) @(negedge clk);
         chk("R3 rxd step", rxd_crs, rxd_fin, int'(VEC[i][7:0]));
         chk("R5 rxt offset", rxt_crs, rxt_fin, (int'(VEC[i][7:0]) + 96) % NC);
      end

      // R9 lockout: sample held for 1+RXL edges gives only one step
      rx_vld = 1; rx_early = 1;
      repeat (1 + RXL) @(negedge clk);
      rx_vld = 0; rx_early = 0;
      chk("R9 lockout", rxd_crs, rxd_fin, 1);
      rx_pulse(1, 0);
      chk("R9 after lockout", rxd_crs, rxd_fin, 2);

      // R6 outside window far samples ignored
      for (int k = 0; k < 7; k++) far_smp(1, 0);
      chk("R6 no window", tx_crs, tx_fin, 0);

      // R7 votes
      cal_win = 1;
      for (int k = 0; k < 4; k++) far_smp(1, 0);
      for (int k = 0; k < 3; k++) far_smp(0, 1);
      chk("R7 early majority", tx_crs, tx_fin, 1);
      far_smp(1, 0); far_smp(1, 0); far_smp(0, 1); far_smp(0, 1);
      far_smp(0, 0); far_smp(0, 0); far_smp(1, 1);
      chk("R7 tie no step", tx_crs, tx_fin, 1);
      for (int k = 0; k < 7; k++) far_smp(0, 1);
      chk("R7 late majority", tx_crs, tx_fin, 0);
      for (int k = 0; k < 7; k++) far_smp(0, 1);
      chk("R4 tx wrap down", tx_crs, tx_fin, 191);

      // R8 partial vote discarded when window drops
      for (int k = 0; k < 4; k++) far_smp(0, 1);
      cal_win = 0;
      @(negedge clk);
      cal_win = 1;
      far_smp(1, 0);
      for (int k = 0; k < 6; k++) far_smp(0, 0);
      chk("R8 vote cleared", tx_crs, tx_fin, 0);
      cal_win = 0;

      // R10 override with folding, loop frozen
      ovr_code = {8'd10, 8'd200, 8'd150, 8'd5};
      ovr_en = 4'b0111;
      @(negedge clk);
      chk("R10 div ovr", div_crs, div_fin, 5);
      chk("R10 tx ovr", tx_crs, tx_fin, 150);
      chk("R10 rxd fold", rxd_crs, rxd_fin, 8);
      chk("R5 rxt under rxd ovr", rxt_crs, rxt_fin, 104);
      rx_pulse(1, 0);
      rx_pulse(1, 0);
      ovr_en = 4'b1000;
      @(negedge clk);
      chk("R10 rxt ovr", rxt_crs, rxt_fin, 10);
      ovr_en = 4'b0000;
      @(negedge clk);
      chk("R10 rxd loop kept", rxd_crs, rxd_fin, 2);
      chk("R11 div fixed", div_crs, div_fin, DIVC);
      chk("R6 tx kept", tx_crs, tx_fin, 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule